// File: doc/BRIEF.md
# Actuator Command Range Guard

This block sits between a control computation and the actuators it drives. It checks each command vector before the vector is applied. The vector may hold positions, modal amplitudes or feedforward currents. Elements arrive one per valid cycle, and a last marker flags the final element. Each element is compared against its own signed, inclusive lower and upper bound. The block keeps the vector it last applied. When the marker arrives, it decides what becomes the new applied vector, then plays that vector out as a contiguous stream.

Two recovery policies are available. Under the skip policy, a single out-of-range element rejects the whole update, and the held vector is replayed unchanged. Under the patch policy, only the offending elements take their previously applied values, and all in-range elements are applied. With every vector the block also reports a flag and the number of elements that broke their bounds.

Top module: `cmd_limiter`

## Requirements
- R1: A vector is exactly N elements. The element with index i is the i-th valid input counted from the start of the vector. It is checked against `lo_lim[i*W +: W]` and `hi_lim[i*W +: W]`. `in_last` is raised together with element N-1.
- R2: An element is out of range exactly when, read as a two's-complement number, it is below its lower bound or above its upper bound. A value equal to either bound is in range.
- R3: With `policy` = 0 (skip), if any element is out of range, the held vector is left unchanged and the vector played out equals the previously held vector.
- R4: With `policy` = 0 and all elements in range, the whole new vector is applied and played out.
- R5: With `policy` = 1 (patch), each out-of-range element is replaced by the held value at the same index, and each in-range element is applied.
- R6: The held vector changes only to the values that were played out. A later substitution therefore uses the last applied values, not rejected inputs.
- R7: On the clock edge that samples the last element, `exceed` and `exceed_cnt` take the flag and the count of out-of-range elements for that vector. They hold until the next vector's last element. `exceed` is 1 exactly when the count is non-zero.
- R8: After the edge that samples the last element, `out_valid` is high for exactly N consecutive cycles. Element k becomes visible after the k+1-th following edge. `out_last` is high only with element N-1.
- R9: After reset the held vector is all zeros, and `out_valid`, `out_last`, `exceed` and `exceed_cnt` are 0.
- R10: The policy is sampled with element 0 of a vector. Changing `policy` later in the same vector has no effect on that vector.
- R11: Cycles with `in_valid` low are ignored. They neither advance the element index nor change the held vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An element is present on `in_data` |
| in_last | input | 1 | Marks element N-1 of the vector |
| in_data | input | W | Signed command element |
| lo_lim | input | N*W | Per-element signed lower bounds, element i at bits i*W +: W |
| hi_lim | input | N*W | Per-element signed upper bounds, element i at bits i*W +: W |
| policy | input | 1 | 0 = skip whole update, 1 = patch offending elements |
| out_valid | output | 1 | An applied element is present on `out_data` |
| out_last | output | 1 | Marks the final applied element |
| out_data | output | W | Applied command element |
| exceed | output | 1 | The latest vector had an out-of-range element |
| exceed_cnt | output | $clog2(N+1) | Number of out-of-range elements in the latest vector |

## Verification
Assertions watch several behaviours on every cycle. They check that the input framing puts the last marker on element N-1 and that a skipped update leaves the held vector untouched. They also check that a clean vector is taken whole, that the flag agrees with the count, and that the played-out stream is contiguous and closed by its marker. Other behaviours can only be shown by the bench's scenarios against its own model of the held vector. These are the inclusive bound comparisons at and one past each bound, and element-wise patching from previously applied values. They also include the first-element policy sampling and the tolerance of idle gaps.

// File: rtl/cmd_limiter.sv
module cmd_limiter #(
  parameter int W = 16,
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_last,
  input  logic signed [W-1:0]   in_data,
  input  logic [N*W-1:0]        lo_lim,
  input  logic [N*W-1:0]        hi_lim,
  input  logic                  policy,
  output logic                  out_valid,
  output logic                  out_last,
  output logic signed [W-1:0]   out_data,
  output logic                  exceed,
  output logic [$clog2(N+1)-1:0] exceed_cnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N+1);

  logic [IW-1:0]             idx, rd_idx;
  logic                      pol_q, rd_on;
  logic [N-1:0][W-1:0]       cand_q, prev_q, nb_val;
  logic [N-1:0]              bad_q, nb_bad;
  logic signed [W-1:0]       lo_cur, hi_cur;
  logic                      in_bad, pol_cur, done;
  logic [CW-1:0]             cnt_now;

  assign lo_cur  = lo_lim[idx*W +: W];
  assign hi_cur  = hi_lim[idx*W +: W];
  assign in_bad  = (in_data < lo_cur) || (in_data > hi_cur);
  assign pol_cur = (idx == '0) ? policy : pol_q;
  assign done    = in_valid && in_last;

  always_comb begin
    cnt_now = '0;
    for (int k = 0; k < N; k++) begin
      nb_bad[k] = (IW'(k) == idx) ? in_bad  : bad_q[k];
      nb_val[k] = (IW'(k) == idx) ? in_data : cand_q[k];
      cnt_now   = cnt_now + CW'(nb_bad[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; rd_idx <= '0; pol_q <= 1'b0; rd_on <= 1'b0;
      cand_q <= '0; prev_q <= '0; bad_q <= '0;
      out_valid <= 1'b0; out_last <= 1'b0; out_data <= '0;
      exceed <= 1'b0; exceed_cnt <= '0;
    end else begin
      if (rd_on) begin
        out_valid <= 1'b1;
        out_data  <= prev_q[rd_idx];
        out_last  <= (rd_idx == IW'(N-1));
        rd_idx    <= rd_idx + 1'b1;
        if (rd_idx == IW'(N-1)) rd_on <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
      if (in_valid) begin
        cand_q[idx] <= in_data;
        bad_q[idx]  <= in_bad;
        pol_q       <= pol_cur;
        idx         <= in_last ? '0 : idx + 1'b1;
      end
      if (done) begin
        for (int k = 0; k < N; k++)
          if (pol_cur ? !nb_bad[k] : (cnt_now == '0)) prev_q[k] <= nb_val[k];
        exceed     <= (cnt_now != '0);
        exceed_cnt <= cnt_now;
        rd_on      <= 1'b1;
        rd_idx     <= '0;
      end
    end
  end

  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idx == IW'(N-1));
  assert_skip_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pol_cur && (cnt_now != '0) |=> $stable(prev_q));
  assert_clean_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cnt_now == '0) |=> prev_q == $past(nb_val));
  assert_flag_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exceed == (exceed_cnt != '0));
  assert_stream_contig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
  assert_last_in_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: tb/tb_cmd_limiter.sv
module tb_cmd_limiter;
  localparam int W = 16;
  localparam int N = 8;
  localparam int CW = $clog2(N+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, policy = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic [N-1:0][W-1:0] lo_p, hi_p;
  logic out_valid, out_last, exceed;
  logic signed [W-1:0] out_data;
  logic [CW-1:0] exceed_cnt;

  int checks = 0, fails = 0;
  int hold [N];

  always #2 clk = ~clk;

  cmd_limiter #(.W(W), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .lo_lim(lo_p), .hi_lim(hi_p), .policy(policy),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
    .exceed(exceed), .exceed_cnt(exceed_cnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lo_of(int i);
    return int'($signed(lo_p[i]));
  endfunction
  function automatic int hi_of(int i);
    return int'($signed(hi_p[i]));
  endfunction

  function automatic bit is_bad(int i, int v);
    return (v < lo_of(i)) || (v > hi_of(i));
  endfunction

  function automatic int rnd_val(int i);
    case ($urandom % 8)
      0: return lo_of(i);
      1: return hi_of(i);
      2: return lo_of(i) - 1;
      3: return hi_of(i) + 1;
      4: return lo_of(i) - 1 - int'($urandom % 500);
      default: return lo_of(i) + int'($urandom % (hi_of(i) - lo_of(i) + 1));
    endcase
  endfunction

  task automatic set_limits();
    for (int i = 0; i < N; i++) begin
      lo_p[i] = W'(-int'($urandom % 1000) - 1);
      hi_p[i] = W'(int'($urandom % 1000));
    end
  endtask

  task automatic send_vec(input int v [N], input bit pol0, input bit polr, input int gap);
    int cnt = 0;
    int nxt [N];
    for (int i = 0; i < N; i++) cnt += int'(is_bad(i, v[i]));
    for (int i = 0; i < N; i++)
      nxt[i] = (pol0 ? is_bad(i, v[i]) : (cnt != 0)) ? hold[i] : v[i];
    for (int i = 0; i < N; i++) begin
      if (gap > 0 && i > 0) begin
        in_valid = 1'b0; in_last = 1'b1; policy = ~polr; in_data = W'($urandom);
        repeat (gap) begin @(posedge clk); @(negedge clk); end
      end
      in_valid = 1'b1;
      in_data  = W'(v[i]);
      in_last  = (i == N-1);
      policy   = (i == 0) ? pol0 : polr;
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk("R7 exceed", int'(exceed), int'(cnt != 0));
    chk("R7 exceed_cnt", int'(exceed_cnt), cnt);
    for (int k = 0; k < N; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 out_valid", int'(out_valid), 1);
      chk("R8 out_last", int'(out_last), int'(k == N-1));
      chk(pol0 ? "R5 R6 patch data" : (cnt != 0 ? "R3 skip data" : "R4 accept data"),
          int'(out_data), nxt[k]);
    end
    @(posedge clk); @(negedge clk);
    chk("R8 stream ends", int'(out_valid), 0);
    for (int i = 0; i < N; i++) hold[i] = nxt[i];
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v [N];
    void'($urandom(32'd2718));
    for (int i = 0; i < N; i++) hold[i] = 0;
    set_limits();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 out_last", int'(out_last), 0);
    chk("R9 exceed", int'(exceed), 0);
    chk("R9 exceed_cnt", int'(exceed_cnt), 0);

    // R9 R3: one bad element under skip replays the all-zero reset vector
    for (int i = 0; i < N; i++) v[i] = lo_of(i);
    v[3] = hi_of(3) + 1;
    send_vec(v, 1'b0, 1'b0, 0);

    // R4: all in range, skip policy
    for (int i = 0; i < N; i++) v[i] = hi_of(i);
    send_vec(v, 1'b0, 1'b0, 0);

    // R2 R5: bounds exactly and one past, patch policy
    for (int i = 0; i < N; i++)
      v[i] = (i % 4 == 0) ? lo_of(i) : (i % 4 == 1) ? hi_of(i) :
             (i % 4 == 2) ? lo_of(i) - 1 : hi_of(i) + 1;
    send_vec(v, 1'b1, 1'b1, 0);

    // R6: patch again, substitutions must come from applied values
    for (int i = 0; i < N; i++) v[i] = (i % 2 == 0) ? lo_of(i) - 7 : 0;
    send_vec(v, 1'b1, 1'b1, 0);

    // R10: policy flips after element 0 (skip sampled)
    for (int i = 0; i < N; i++) v[i] = 1;
    v[N-1] = hi_of(N-1) + 2;
    send_vec(v, 1'b0, 1'b1, 0);
    // R10: patch sampled, skip asserted afterwards
    send_vec(v, 1'b1, 1'b0, 0);

    // R11: idle gaps between elements
    for (int i = 0; i < N; i++) v[i] = lo_of(i) + 1;
    send_vec(v, 1'b0, 1'b0, 3);
    v[2] = lo_of(2) - 100;
    send_vec(v, 1'b1, 1'b1, 2);

    // R1 R2 R3 R4 R5: random vectors
    for (int t = 0; t < 60; t++) begin
      if (t % 10 == 0) set_limits();
      for (int i = 0; i < N; i++) v[i] = rnd_val(i);
      send_vec(v, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 3));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule